// File: doc/BRIEF.md
# Prioritized Interrupt Request and Service Tracker

This block follows interrupt vectors from arrival to retirement for one processor. It keeps three vector-wide bitmaps: one for vectors waiting to be served, one for vectors currently being served, and one that remembers which vectors arrived level-triggered. It also holds a task priority byte. From the task priority and the highest vector being served it forms a processor priority. It offers the highest waiting vector only when that vector's priority class is above the processor priority.

A source raises a request by presenting a vector, a level flag and a valid strobe. The processor takes the offered vector with an acknowledge strobe, which moves that vector from waiting to in service. When the processor is finished with an interrupt it pulses end-of-interrupt. This retires the highest in-service vector. If the retired vector was level-triggered, its number is sent out on a one-cycle notification so that the interrupt source can re-arm. An enable input gates both acceptance of new requests and the offer of pending vectors.

Top module: `vec_prio_tracker`

## Requirements
- R1: When a vector is offered, `pend_vec` is the highest-numbered vector waiting to be served, and that vector's waiting bit is set.
- R2: `ppr` equals the full task priority byte when the task priority's upper nibble (bits 7:4) is at least the upper nibble of the highest in-service vector. Otherwise `ppr` is that vector with bits 3:0 zeroed. When nothing is in service, the in-service vector is taken as 0.
- R3: `pend_valid` is high only when `enable` is high and the highest waiting vector, with bits 3:0 zeroed, is strictly greater than `ppr`.
- R4: An `ack` sampled while `pend_valid` is high marks the offered vector as in service and clears its waiting bit at that same clock edge. An `ack` while nothing is offered has no effect.
- R5: An `eoi` pulse removes the highest in-service vector. An `eoi` while nothing is in service changes nothing and produces no notification.
- R6: A request with `req_level`=1 records the vector as level-triggered. When that vector is later retired, `leoi_valid` is high for exactly one cycle with `leoi_vec` set to it, in the cycle after the `eoi` edge. A level request for a vector that is already waiting is dropped and does not mark the vector as level-triggered.
- R7: A request sampled while `enable` is low is discarded and is not offered after `enable` rises again.
- R8: After a synchronous active-low reset, all three bitmaps and the task priority are zero. Outputs are then `pend_valid`=0, `ppr`=0 and `leoi_valid`=0.
- R9: A task priority write keeps only bits 7:0 of `tpr_wdata`.
- R10: When a request and an acknowledge name the same vector in the same cycle, the vector becomes in service and also stays waiting.
- R11: Requests for vectors 0 to 15 are ignored, and such vectors are never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; gates request acceptance and the offer |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered request |
| ack | input | 1 | Processor takes the offered vector |
| pend_valid | output | 1 | A vector is offered |
| pend_vec | output | 8 | Highest waiting vector |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data |
| eoi | input | 1 | End-of-interrupt strobe |
| leoi_valid | output | 1 | A level-triggered vector was just retired |
| leoi_vec | output | 8 | Vector retired with level trigger |
| ppr | output | 8 | Current processor priority |

## Verification
Every stimulus (request, acknowledge, task priority write, end-of-interrupt, enable change) is registered at one clock edge. The resulting `pend_valid`, `pend_vec` and `ppr` values follow from that state through logic with no further register, so they are due one edge after the stimulus. `leoi_valid` and `leoi_vec` are registered at the same edge that samples `eoi`, so they are also due one edge later, and they fall again at the edge after that. The bench drives its inputs on the falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. It then steps once more to confirm that the notification lasts only one cycle.

// File: rtl/vpt_pkg.sv
// Shared constants and helpers for the vector priority tracker.
// Assumes vectors are a power-of-two count, with an even-width vector number
// split into a priority class (upper half) and a sub-priority (lower half).
package vpt_pkg;

    localparam int VPT_VEC_W = 8;

    // Zero the sub-priority half of a vector, leaving its class.
    function automatic logic [VPT_VEC_W-1:0] class_of(input logic [VPT_VEC_W-1:0] v);
        logic [VPT_VEC_W-1:0] m;
        m = '0;
        m[VPT_VEC_W-1:VPT_VEC_W/2] = v[VPT_VEC_W-1:VPT_VEC_W/2];
        return m;
    endfunction

endpackage

// File: rtl/vpt_hifind.sv
// Highest-set-bit finder for a flat bit vector.
// Purely combinational. Assumes WIDTH >= 2. When no bit is set,
// any_o is 0 and idx_o is 0.
module vpt_hifind #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan upward so that the last set bit found is the highest one.
    always_comb begin
        any_o = |bits_i;
        idx_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vpt_scan.sv
// Two-level highest-vector search over a vector-wide bitmap.
// The bitmap is cut into words of WORD_W bits. Each word finds its own top
// bit, and a second finder picks the highest non-empty word. Assumes the
// vector count divides into at least two words.
module vpt_scan #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    localparam int NVEC   = 2 ** VEC_W,
    localparam int NWORDS = NVEC / WORD_W,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int WRD_W  = $clog2(NWORDS)
) (
    input  logic [NVEC-1:0]  map_i,
    output logic             any_o,
    output logic [VEC_W-1:0] top_o
);

    logic [NWORDS-1:0] word_any;
    logic [BIT_W-1:0]  word_idx [NWORDS];
    logic [WRD_W-1:0]  top_word;

    // One finder per word of the bitmap.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        vpt_hifind #(.WIDTH(WORD_W)) u_word (
            .bits_i (map_i[w*WORD_W +: WORD_W]),
            .any_o  (word_any[w]),
            .idx_o  (word_idx[w])
        );
    end

    // Pick the highest word that has any bit set.
    vpt_hifind #(.WIDTH(NWORDS)) u_words (
        .bits_i (word_any),
        .any_o  (any_o),
        .idx_o  (top_word)
    );

    // The vector number is the word index above the bit index.
    always_comb begin
        top_o = {top_word, word_idx[top_word]};
    end

endmodule

// File: rtl/vpt_prio.sv
// Processor-priority and delivery decision.
// The task priority wins when its class is at least the class of the highest
// in-service vector. Otherwise the in-service class is used. A waiting vector
// is deliverable only when its class is strictly above the result and the
// block is enabled.
module vpt_prio
    import vpt_pkg::*;
#(
    parameter int VEC_W = 8,
    localparam int HALF = VEC_W / 2
) (
    input  logic             enable_i,
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_any_i,
    input  logic [VEC_W-1:0] isr_top_i,
    input  logic             irr_any_i,
    input  logic [VEC_W-1:0] irr_top_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             deliver_o
);

    logic [VEC_W-1:0] isr_eff;

    // Form the processor priority from the task priority and the in-service top.
    always_comb begin
        isr_eff = isr_any_i ? isr_top_i : '0;
        if (tpr_i[VEC_W-1:HALF] >= isr_eff[VEC_W-1:HALF]) ppr_o = tpr_i;
        else ppr_o = class_of(isr_eff);
    end

    // Offer the top waiting vector only when its class beats the priority.
    always_comb begin
        deliver_o = enable_i && irr_any_i && (class_of(irr_top_i) > ppr_o);
    end

endmodule

// File: rtl/vec_prio_tracker.sv
// Interrupt request / in-service tracker with priority-gated delivery.
// Holds waiting, in-service and level-trigger bitmaps plus a task priority.
// It offers the highest deliverable vector, moves it to in service on
// acknowledge, and retires the highest in-service vector on end-of-interrupt,
// notifying level-triggered ones. Assumes single-cycle strobes sampled on the
// rising edge, with a synchronous active-low reset.
module vec_prio_tracker #(
    parameter int VEC_W    = 8,
    parameter int WORD_W   = 32,
    parameter int MIN_VEC  = 16,
    parameter int TPR_IN_W = 32,
    localparam int NVEC    = 2 ** VEC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                req_valid,
    input  logic [VEC_W-1:0]    req_vec,
    input  logic                req_level,
    input  logic                ack,
    output logic                pend_valid,
    output logic [VEC_W-1:0]    pend_vec,
    input  logic                tpr_we,
    input  logic [TPR_IN_W-1:0] tpr_wdata,
    input  logic                eoi,
    output logic                leoi_valid,
    output logic [VEC_W-1:0]    leoi_vec,
    output logic [VEC_W-1:0]    ppr
);

    logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
    logic [NVEC-1:0]  irr_d, isr_d, tmr_d;
    logic [VEC_W-1:0] tpr_q;

    logic             irr_any, isr_any;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic             deliver;

    logic req_ok, ack_take, req_hit_ack, level_dup, req_set, eoi_go;

    // Search of the waiting bitmap.
    vpt_scan #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_irr_scan (
        .map_i (irr_q),
        .any_o (irr_any),
        .top_o (irr_top)
    );

    // Search of the in-service bitmap.
    vpt_scan #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_scan (
        .map_i (isr_q),
        .any_o (isr_any),
        .top_o (isr_top)
    );

    // Priority and delivery decision.
    vpt_prio #(.VEC_W(VEC_W)) u_prio (
        .enable_i  (enable),
        .tpr_i     (tpr_q),
        .isr_any_i (isr_any),
        .isr_top_i (isr_top),
        .irr_any_i (irr_any),
        .irr_top_i (irr_top),
        .ppr_o     (ppr),
        .deliver_o (deliver)
    );

    assign pend_valid = deliver;
    assign pend_vec   = irr_top;

    // Qualify the incoming strobes against state and enable.
    always_comb begin
        req_ok      = enable && req_valid && (req_vec >= VEC_W'(MIN_VEC));
        ack_take    = ack && deliver;
        req_hit_ack = ack_take && (req_vec == irr_top);
        level_dup   = req_level && irr_q[req_vec] && !req_hit_ack;
        req_set     = req_ok && !level_dup;
        eoi_go      = eoi && isr_any;
    end

    // Next-state of the three bitmaps; the request is applied last so it wins.
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (ack_take) begin
            irr_d[irr_top] = 1'b0;
            isr_d[irr_top] = 1'b1;
        end
        if (eoi_go) begin
            isr_d[isr_top] = 1'b0;
            tmr_d[isr_top] = 1'b0;
        end
        if (req_set) begin
            irr_d[req_vec] = 1'b1;
            if (req_level) tmr_d[req_vec] = 1'b1;
        end
    end

    // Bitmap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
        end
    end

    // Task priority register keeps only the vector-width low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
    end

    // One-cycle notification of a retired level-triggered vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leoi_valid <= 1'b0;
            leoi_vec   <= '0;
        end else begin
            leoi_valid <= eoi_go && tmr_q[isr_top];
            leoi_vec   <= eoi_go ? isr_top : leoi_vec;
        end
    end

    // R9: a write lands its low byte in the task priority.
    p_tpr_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tpr_we) |-> tpr_q == $past(tpr_wdata[VEC_W-1:0]));

    // R4: an accepted acknowledge leaves its vector in service.
    p_ack_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ack) && $past(pend_valid) && !$past(eoi)
        |-> isr_q[$past(pend_vec)]);

    // R3: nothing is offered while the block is off.
    p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pend_valid);

    // R1: an offered vector is really waiting.
    p_pend_real_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> irr_q[pend_vec]);

    // R11: the reserved low vectors never enter either bitmap.
    p_low_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irr_q[MIN_VEC-1:0] == '0 && isr_q[MIN_VEC-1:0] == '0);

    // R5: a notification only follows an end-of-interrupt.
    p_leoi_after_eoi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && leoi_valid |-> $past(eoi));

endmodule

// File: tb/sim_vec_prio_tracker.sv
module sim_vec_prio_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        req_level = 1'b0;
    logic        ack = 1'b0;
    logic        pend_valid;
    logic [7:0]  pend_vec;
    logic        tpr_we = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        eoi = 1'b0;
    logic        leoi_valid;
    logic [7:0]  leoi_vec;
    logic [7:0]  ppr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_prio_tracker u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .ack(ack), .pend_valid(pend_valid), .pend_vec(pend_vec),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .eoi(eoi),
        .leoi_valid(leoi_valid), .leoi_vec(leoi_vec), .ppr(ppr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input int v, input bit lvl);
        req_valid = 1'b1; req_vec = 8'(v); req_level = lvl;
        step();
        req_valid = 1'b0; req_level = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic do_tpr(input logic [31:0] d);
        tpr_we = 1'b1; tpr_wdata = d; step(); tpr_we = 1'b0;
    endtask

    function automatic int cls(input int v);
        return v & 8'hF0;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R8: reset state
        check(pend_valid == 0, "R8 pend_valid", pend_valid, 0);
        check(ppr == 0, "R8 ppr", ppr, 0);
        check(leoi_valid == 0, "R8 leoi_valid", leoi_valid, 0);
        rst_n = 1'b1; enable = 1'b1;
        step();

        // R1 R4 R5: edge-triggered sweep over every valid vector
        for (int v = 16; v < 256; v++) begin
            do_req(v, 1'b0);
            check(pend_valid && pend_vec == 8'(v), "R1 sweep offer", pend_vec, v);
            do_ack();
            check(ppr == 8'(cls(v)), "R4 sweep in service", ppr, cls(v));
            check(!pend_valid, "R4 sweep waiting cleared", pend_valid, 0);
            do_eoi();
            check(ppr == 0 && !leoi_valid, "R5 sweep edge retire", {leoi_valid, ppr}, 0);
        end

        // R6: level-triggered sweep, notification lasts one cycle
        for (int v = 16; v < 256; v++) begin
            do_req(v, 1'b1);
            do_ack();
            do_eoi();
            check(leoi_valid && leoi_vec == 8'(v), "R6 level notify", leoi_vec, v);
            step();
            check(!leoi_valid, "R6 notify one cycle", leoi_valid, 0);
        end

        // R1: highest of several waiting vectors
        do_req(8'h30, 0); do_req(8'h91, 0); do_req(8'h45, 0);
        check(pend_valid && pend_vec == 8'h91, "R1 highest", pend_vec, 8'h91);
        do_ack();
        check(!pend_valid && ppr == 8'h90, "R3 class blocked by isr", {pend_valid, ppr}, 8'h90);
        do_eoi();
        check(pend_valid && pend_vec == 8'h45, "R1 next highest", pend_vec, 8'h45);
        do_ack(); do_eoi(); do_ack(); do_eoi();
        check(!pend_valid && ppr == 0, "R5 drained", {pend_valid, ppr}, 0);

        // R5: nested service retires the highest first; empty eoi is harmless
        do_req(8'h30, 0); do_ack();
        do_req(8'h80, 1); do_ack();
        check(ppr == 8'h80, "R2 nested ppr", ppr, 8'h80);
        do_eoi();
        check(ppr == 8'h30 && leoi_valid && leoi_vec == 8'h80, "R5 nested eoi", ppr, 8'h30);
        do_eoi();
        check(ppr == 0 && !leoi_valid, "R5 second eoi", ppr, 0);
        do_eoi();
        check(ppr == 0 && !leoi_valid && !pend_valid, "R5 empty eoi", {leoi_valid, ppr}, 0);

        // R9: only the low byte of the task priority write is kept
        do_tpr(32'h1234_56AB);
        check(ppr == 8'hAB, "R9 tpr byte", ppr, 8'hAB);

        // R3: class must be strictly above the priority
        do_tpr(32'h50);
        do_req(8'h5F, 0);
        check(!pend_valid, "R3 equal class blocked", pend_valid, 0);
        do_req(8'h60, 0);
        check(pend_valid && pend_vec == 8'h60, "R3 higher class offered", pend_vec, 8'h60);
        do_ack(); do_eoi();
        do_tpr(32'h0);
        check(pend_valid && pend_vec == 8'h5F, "R3 released by tpr", pend_vec, 8'h5F);
        do_ack(); do_eoi();

        // R2: task priority against in-service class
        do_tpr(32'h25);
        do_req(8'h91, 0); do_ack();
        check(ppr == 8'h90, "R2 isr class wins", ppr, 8'h90);
        do_tpr(32'hA3);
        check(ppr == 8'hA3, "R2 tpr wins", ppr, 8'hA3);
        do_tpr(32'h97);
        check(ppr == 8'h97, "R2 tpr equal class wins", ppr, 8'h97);
        do_eoi(); do_tpr(32'h0);

        // R6: duplicate level request on a waiting vector is dropped
        do_req(8'h40, 0);
        do_req(8'h40, 1);
        do_ack(); do_eoi();
        check(!leoi_valid, "R6 duplicate level dropped", leoi_valid, 0);

        // R7: requests while disabled are discarded; disabled hides offers
        enable = 1'b0;
        do_req(8'h70, 0);
        check(!pend_valid, "R3 disabled no offer", pend_valid, 0);
        enable = 1'b1; step();
        check(!pend_valid, "R7 disabled request lost", pend_valid, 0);
        do_req(8'h70, 0);
        enable = 1'b0; step();
        check(!pend_valid, "R3 disable hides offer", pend_valid, 0);
        enable = 1'b1; step();
        check(pend_valid && pend_vec == 8'h70, "R3 offer returns", pend_vec, 8'h70);
        do_ack(); do_eoi();

        // R10: same-cycle request and acknowledge of one vector
        do_req(8'h50, 0);
        req_valid = 1'b1; req_vec = 8'h50; ack = 1'b1;
        step();
        req_valid = 1'b0; ack = 1'b0;
        check(ppr == 8'h50 && !pend_valid, "R10 in service", ppr, 8'h50);
        do_eoi();
        check(pend_valid && pend_vec == 8'h50, "R10 still waiting", pend_vec, 8'h50);
        do_ack(); do_eoi();
        check(!pend_valid && ppr == 0, "R10 drained", {pend_valid, ppr}, 0);

        // R11: reserved vectors ignored
        do_req(8'h05, 0); do_req(8'h0F, 1);
        check(!pend_valid, "R11 low vectors", pend_valid, 0);
        do_ack(); do_eoi();
        check(ppr == 0 && !leoi_valid, "R11 nothing in service", ppr, 0);

        // R4: acknowledge with nothing offered
        do_ack();
        check(ppr == 0, "R4 idle ack", ppr, 0);

        // R8: reset mid-run clears everything
        do_req(8'h90, 1); do_tpr(32'h33); do_req(8'hC0, 0); do_ack();
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        check(!pend_valid && ppr == 0 && !leoi_valid, "R8 mid reset", {pend_valid, ppr}, 0);
        do_eoi();
        check(!leoi_valid, "R8 tmr cleared", leoi_valid, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule